// File: doc/BRIEF.md
# Power-Fail Write-Protect Controller

This block is a clocked supervisor placed between a host bus and a memory array. It watches a digital power-fail flag, which says the supply has dropped below its detect threshold, and decides on every clock whether the host's active-low chip-select, write-strobe and read-enable reach the memory. When the supply is good, the three strobes pass through unchanged. When the flag is raised, no new access may start. An access already under way may finish, but only within a bounded number of cycles. After that the memory is fenced off. In that condition the memory's read-enable is held inactive, so its data pins float and all host strobes are ignored.

When the flag clears, the fence stays up for a long recovery hold so the host has time to settle. Only after this hold does traffic pass again. A new fault during the hold returns the block to full protection, and the hold then starts again from the beginning.

The block also keeps a one-time battery arming latch. The backup cell stays disconnected until the supply has been seen good for the first time. From then on, the backup path is enabled whenever the external backup-select flag is asserted. Comparators and switching hardware are outside the block; their results arrive as digital inputs.

Top module: `pwr_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters the protected state: `wp_on` = 1, `mem_ce_n` = `mem_we_n` = `mem_oe_n` = 1, and `batt_armed` = 0.
- R2: `pfail_async` passes through two synchronizer flops before it is used. A change on it alters the protection state at the third rising edge after the change, and not earlier.
- R3: In the normal state, `wp_on` = 0 and each `mem_*_n` output equals the matching `host_*_n` input.
- R4: If the synchronized power-fail flag is high in the normal state and `host_ce_n` = 1, the next edge enters protection. While protected or recovering, all three `mem_*_n` outputs are 1 whatever the host drives.
- R5: If the synchronized power-fail flag is high in the normal state and `host_ce_n` = 0, the block enters a drain state. In that state the host strobes still pass through and `wp_on` = 0.
- R6: In the drain state, `host_ce_n` = 1 at an edge ends the drain at that edge. A later host access is then blocked.
- R7: If the access has not ended, the drain lasts exactly `WPT_CYCLES` cycles and then protection is forced.
- R8: Once the synchronized flag is low in the protected state, the block spends exactly `CER_CYCLES` cycles recovering with `wp_on` = 1, then returns to normal. Normal is entered only from recovery.
- R9: A synchronized power-fail flag during recovery returns the block to protection at the next edge. The next recovery counts the full `CER_CYCLES` again.
- R10: `batt_armed` is set at the first protected-to-recovery transition after reset, and only a reset clears it. `batt_feed` = `batt_armed` AND `backup_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfail_async | input | 1 | Asynchronous power-fail flag, high when the supply is below threshold |
| backup_sel | input | 1 | High when the supply is near the switch-over level and the backup should be used |
| host_ce_n | input | 1 | Host chip select, active low |
| host_we_n | input | 1 | Host write strobe, active low |
| host_oe_n | input | 1 | Host read enable, active low |
| mem_ce_n | output | 1 | Gated chip select to the memory |
| mem_we_n | output | 1 | Gated write strobe to the memory |
| mem_oe_n | output | 1 | Gated read enable to the memory; high means the data pins float |
| wp_on | output | 1 | High while the memory is fenced off (protected or recovering) |
| batt_armed | output | 1 | Battery isolation has been broken by a first good supply |
| batt_feed | output | 1 | Backup cell is connected to the memory now |

## Verification
The internal state of this block shows up at the ports within one edge of going wrong. A wrong state appears at once as a strobe mismatch: the host strobes either leak through while `wp_on` is high, or they are cut while it is low. A timer that is off by one shifts the edge at which `wp_on` falls after recovery, or at which `mem_ce_n` rises after a stalled drain. The bench therefore samples these outputs on the last cycle before each expected transition and on the first cycle after it. A lost battery latch shows as `batt_feed` staying low while `backup_sel` is high.

// File: rtl/pg_pkg.sv
// Shared types for the power-fail write-protect controller.
// Assumes: nothing beyond a 2-bit state encoding.
package pg_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_PROT    = 2'd2,
        ST_RECOVER = 2'd3
    } pg_state_e;
endpackage

// File: rtl/pg_sync2.sv
// Two-flop synchronizer for a level flag.
// Assumes: the input is a slow level. Reset loads RST_VAL so the
// output starts in the safe sense.
module pg_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;

    // Shift the level through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/pg_timer.sv
// Down-counter used for both the drain timeout and the recovery hold.
// Assumes: ld has priority; the count stops at zero and never wraps.
module pg_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    // Load a new window or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (ld)             cnt_q <= ld_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R7/R8: an expired window stays expired until the next load.
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && zero) |=> zero);
endmodule

// File: rtl/pg_fsm.sv
// Protection state machine: normal, drain, protected, recovering.
// Also holds the one-time battery arming latch.
// Assumes: pf_s is already synchronized. tmr_zero comes from a timer
// that this module loads on entry to drain and to recovery.
module pg_fsm #(
    parameter int unsigned WPT_CYCLES = 25000,
    parameter int unsigned CER_CYCLES = 20000000,
    parameter int unsigned CW         = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pf_s,
    input  logic          host_ce_n,
    input  logic          tmr_zero,
    output logic          tmr_ld,
    output logic [CW-1:0] tmr_val,
    output logic          pass_en,
    output logic          wp_on,
    output logic          batt_armed
);
    import pg_pkg::*;

    localparam logic [CW-1:0] WPT_LD = CW'(WPT_CYCLES - 1);
    localparam logic [CW-1:0] CER_LD = CW'(CER_CYCLES - 1);

    pg_state_e state_q, state_d;

    // Choose the next state and any timer load.
    always_comb begin
        state_d = state_q;
        tmr_ld  = 1'b0;
        tmr_val = WPT_LD;
        unique case (state_q)
            ST_NORMAL: if (pf_s) begin
                if (host_ce_n) state_d = ST_PROT;
                else begin
                    state_d = ST_DRAIN;
                    tmr_ld  = 1'b1;
                end
            end
            ST_DRAIN:   if (host_ce_n || tmr_zero) state_d = ST_PROT;
            ST_PROT:    if (!pf_s) begin
                state_d = ST_RECOVER;
                tmr_ld  = 1'b1;
                tmr_val = CER_LD;
            end
            ST_RECOVER: if (pf_s) state_d = ST_PROT;
                        else if (tmr_zero) state_d = ST_NORMAL;
            default:    state_d = ST_PROT;
        endcase
    end

    // Register the state; reset lands in protection.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PROT;
        else        state_q <= state_d;
    end

    // Break battery isolation on the first good supply; sticky until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) batt_armed <= 1'b0;
        else if (state_q == ST_PROT && !pf_s) batt_armed <= 1'b1;
    end

    assign pass_en = (state_q == ST_NORMAL) || (state_q == ST_DRAIN);
    assign wp_on   = !pass_en;

    // R4: a fault with no access in flight fences at the next edge.
    assert_idle_fence_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && pf_s && host_ce_n) |=> (state_q == ST_PROT));
    // R7: an expired drain window forces protection.
    assert_drain_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && tmr_zero && !host_ce_n) |=> (state_q == ST_PROT));
    // R6: an access that ends closes the drain.
    assert_drain_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && host_ce_n) |=> (state_q == ST_PROT));
    // R9: a fault during recovery returns to protection.
    assert_refault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER && pf_s) |=> (state_q == ST_PROT));
    // R8: normal is entered only from an expired recovery.
    assert_unlock_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && $past(state_q) != ST_NORMAL)
        |-> ($past(state_q) == ST_RECOVER && $past(tmr_zero)));
    // R10: the battery latch never falls outside reset.
    assert_latch_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(batt_armed));
endmodule

// File: rtl/pwr_guard.sv
// Power-fail write-protect controller top.
// Gates the host strobes to the memory from the protection state.
// Assumes: the strobes are active low. Holding mem_oe_n high floats the
// memory data pins.
module pwr_guard #(
    parameter int unsigned WPT_CYCLES = 25000,
    parameter int unsigned CER_CYCLES = 20000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pfail_async,
    input  logic backup_sel,
    input  logic host_ce_n,
    input  logic host_we_n,
    input  logic host_oe_n,
    output logic mem_ce_n,
    output logic mem_we_n,
    output logic mem_oe_n,
    output logic wp_on,
    output logic batt_armed,
    output logic batt_feed
);
    localparam int unsigned MAXW = (WPT_CYCLES > CER_CYCLES) ? WPT_CYCLES : CER_CYCLES;
    localparam int unsigned CW   = $clog2(MAXW + 1);

    logic          pf_s;
    logic          tmr_ld;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    logic          pass_en;

    pg_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pfail_async), .q_sync(pf_s)
    );

    pg_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .ld(tmr_ld), .ld_val(tmr_val), .zero(tmr_zero)
    );

    pg_fsm #(.WPT_CYCLES(WPT_CYCLES), .CER_CYCLES(CER_CYCLES), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pf_s(pf_s), .host_ce_n(host_ce_n),
        .tmr_zero(tmr_zero), .tmr_ld(tmr_ld), .tmr_val(tmr_val),
        .pass_en(pass_en), .wp_on(wp_on), .batt_armed(batt_armed)
    );

    // Pass strobes only while access is allowed; otherwise hold them idle.
    always_comb begin
        mem_ce_n = pass_en ? host_ce_n : 1'b1;
        mem_we_n = pass_en ? host_we_n : 1'b1;
        mem_oe_n = pass_en ? host_oe_n : 1'b1;
    end

    assign batt_feed = batt_armed & backup_sel;

    // R4: while fenced, no strobe reaches the memory.
    assert_fence_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wp_on |-> (mem_ce_n && mem_we_n && mem_oe_n));
    // R10: backup feed requires an armed battery.
    assert_feed_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        batt_feed |-> batt_armed);
endmodule

// File: tb/pwr_guard_test.sv
// Directed bench: one task per scenario; inputs are driven and outputs
// sampled on falling edges.
module pwr_guard_test;
    localparam int unsigned W = 6;
    localparam int unsigned C = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pfail_async = 1'b1;
    logic backup_sel = 1'b0;
    logic host_ce_n = 1'b1, host_we_n = 1'b1, host_oe_n = 1'b1;
    logic mem_ce_n, mem_we_n, mem_oe_n, wp_on, batt_armed, batt_feed;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pwr_guard #(.WPT_CYCLES(W), .CER_CYCLES(C)) uut (
        .clk(clk), .rst_n(rst_n), .pfail_async(pfail_async), .backup_sel(backup_sel),
        .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .wp_on(wp_on), .batt_armed(batt_armed), .batt_feed(batt_feed)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host(input logic ce, input logic we, input logic oe);
        host_ce_n = ce; host_we_n = we; host_oe_n = oe;
    endtask

    // Release the fault and wait through the full recovery into normal.
    task automatic recover_full(input string tag);
        pfail_async = 1'b0;
        step(2 + C);
        chk({tag, " hold last cycle"}, {7'd0, wp_on}, 8'd1);
        step(1);
        chk({tag, " unlocked"}, {7'd0, wp_on}, 8'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pfail_async = 1'b1; backup_sel = 1'b1; host(1'b0, 1'b0, 1'b0);
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 reset strobes", {5'd0, mem_ce_n, mem_we_n, mem_oe_n}, 8'h07);
        chk("R1 reset wp/armed", {6'd0, wp_on, batt_armed}, 8'h02);
        chk("R10 no feed before arming", {7'd0, batt_feed}, 8'd0);
        host(1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_first_power();
        recover_full("R8 first recovery");
        chk("R10 armed after first good supply", {6'd0, batt_armed, batt_feed}, 8'h03);
        backup_sel = 1'b0; #1;
        chk("R10 feed follows select", {7'd0, batt_feed}, 8'd0);
    endtask

    task automatic t_pass();
        host(1'b0, 1'b0, 1'b1); step(1);
        chk("R3 write pattern", {5'd0, mem_ce_n, mem_we_n, mem_oe_n}, 8'h01);
        host(1'b0, 1'b1, 1'b0); step(1);
        chk("R3 read pattern", {5'd0, mem_ce_n, mem_we_n, mem_oe_n}, 8'h02);
        host(1'b1, 1'b1, 1'b1); step(1);
    endtask

    task automatic t_idle_fault();
        pfail_async = 1'b1;
        step(2);
        chk("R2 not yet fenced", {7'd0, wp_on}, 8'd0);
        step(1);
        chk("R2 fenced at third edge", {7'd0, wp_on}, 8'd1);
        host(1'b0, 1'b0, 1'b0); step(2);
        chk("R4 strobes ignored", {5'd0, mem_ce_n, mem_we_n, mem_oe_n}, 8'h07);
        host(1'b1, 1'b1, 1'b1);
        recover_full("R8 idle recovery");
        chk("R10 latch sticky", {7'd0, batt_armed}, 8'd1);
    endtask

    task automatic t_drain_timeout();
        host(1'b0, 1'b0, 1'b1);
        pfail_async = 1'b1;
        step(3);
        chk("R5 drain passes strobes", {4'd0, wp_on, mem_ce_n, mem_we_n, mem_oe_n}, 8'h01);
        step(W - 1);
        chk("R7 last drain cycle", {6'd0, wp_on, mem_ce_n}, 8'h00);
        step(1);
        chk("R7 forced fence", {6'd0, wp_on, mem_ce_n}, 8'h03);
        host(1'b1, 1'b1, 1'b1);
        recover_full("R8 after timeout");
    endtask

    task automatic t_drain_end();
        host(1'b0, 1'b1, 1'b0);
        pfail_async = 1'b1;
        step(3);
        step(2);
        chk("R5 drain read passes", {5'd0, mem_ce_n, mem_we_n, mem_oe_n}, 8'h02);
        host(1'b1, 1'b1, 1'b1);
        step(1);
        host(1'b0, 1'b0, 1'b0); #1;
        chk("R6 new access blocked", {4'd0, wp_on, mem_ce_n, mem_we_n, mem_oe_n}, 8'h0F);
        host(1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_refault();
        pfail_async = 1'b0;
        step(3 + 4);
        chk("R9 recovering", {7'd0, wp_on}, 8'd1);
        pfail_async = 1'b1;
        step(3);
        chk("R9 back to fence", {7'd0, wp_on}, 8'd1);
        recover_full("R9 full recount");
    endtask

    initial begin
        t_reset();
        t_first_power();
        t_pass();
        t_idle_fault();
        t_drain_timeout();
        t_drain_end();
        t_refault();
        t_pass();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule